// File: doc/BRIEF.md
# SPI Status and Fault Logic

This block holds the control bits and status flags of a byte-wide SPI peripheral that can run as a bus master or as a slave. It sits next to a separate shift engine. It receives single-cycle strobes for register accesses: a status read, a control write, and data reads and writes. It also sees the raw slave-select pin level and the busy and byte-complete signals from the shift engine. From these it keeps three control bits (enable, master, select-ignore) and three flags (transfer done, write collision, mode fault). It drives two interrupt requests and holds the received byte.

Each flag is cleared by a two-step sequence. First a status read must see the flag set. Then a later access of the flag's own kind clears it. No write-one-to-clear is used. A mode fault, caused by another device pulling slave-select low while this one is master, turns off the enable and master bits by itself. The peripheral cannot be re-enabled until the fault has been cleared.

Top module: `spi_status_ctrl`

## Requirements
- R1: After reset, ctl_enable, ctl_master, ctl_sel_ignore, done_flag, collide_flag, fault_flag, irq_done, irq_fault and rx_data are all zero.
- R2: ss_n_pin passes through a two-flop synchroniser. When the synchronised level is low while ctl_enable=1, ctl_master=1 and ctl_sel_ignore=0, fault_flag is set on the third clock edge after the pin falls. ctl_enable and ctl_master are cleared on that same edge.
- R3: irq_fault is high only while fault_flag=1 and ctl_sel_ignore=0. While ctl_sel_ignore=1, a low slave-select never sets fault_flag.
- R4: fault_flag is cleared by a ctl_wr that follows a stat_rd taken while fault_flag was set. Any ctl_wr made while fault_flag is set leaves ctl_enable unchanged. ctl_wdata bit 0 = enable, bit 1 = master, bit 2 = select-ignore.
- R5: data_wr while xfer_busy=1 sets collide_flag and keeps tx_load low. With xfer_busy=0, data_wr raises tx_load in the same cycle. collide_flag drives no interrupt.
- R6: collide_flag is cleared by a data_rd or data_wr that follows a stat_rd taken while collide_flag was set.
- R7: xfer_done sets done_flag on the next edge, and irq_done follows done_flag.
- R8: xfer_done with done_flag clear loads rx_byte into rx_data. xfer_done while done_flag is set leaves rx_data unchanged, and no overrun indication exists.
- R9: The armed state is taken only by a status read that sees the flag set. A data or control access made without that arming leaves the flag set. A status read that sees the flag clear disarms it.
- R10: done_flag is cleared by a data_rd or data_wr that follows a stat_rd taken while done_flag was set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stat_rd | input | 1 | Status register read strobe |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Control write data: bit0 enable, bit1 master, bit2 select-ignore |
| data_rd | input | 1 | Data register read strobe |
| data_wr | input | 1 | Data register write strobe |
| ss_n_pin | input | 1 | Raw slave-select pin level, active low |
| xfer_busy | input | 1 | Shift engine is mid-transfer |
| xfer_done | input | 1 | Shift engine finished a byte (one-cycle pulse) |
| rx_byte | input | DATA_W | Byte captured by the shift engine |
| ctl_enable | output | 1 | Peripheral enable bit |
| ctl_master | output | 1 | Master mode bit |
| ctl_sel_ignore | output | 1 | Slave-select ignored as fault source |
| done_flag | output | 1 | Transfer complete flag |
| collide_flag | output | 1 | Write collision flag |
| fault_flag | output | 1 | Mode fault flag |
| irq_done | output | 1 | Transfer-done interrupt request |
| irq_fault | output | 1 | Receiver/error interrupt request |
| tx_load | output | 1 | Load strobe to the shift engine for an accepted write |
| rx_data | output | DATA_W | Held receive byte |

## Verification
A wrong armed latch shows up as a flag that survives its clearing access, or that drops without an arming read. Either is visible on the flag output one edge after the access. A fault path that is off by one synchroniser stage moves the rise of fault_flag, and the drop of ctl_enable, by one cycle. The bench therefore samples that window edge by edge. A receive hold that overwrites shows a changed rx_data right after a second xfer_done. A broken enable lock shows ctl_enable high the cycle after a control write made during a fault.

// File: rtl/spi_stat_pkg.sv
`timescale 1ns/1ps
package spi_stat_pkg;
    localparam int CTL_W       = 3;
    localparam int CTL_BIT_EN  = 0;
    localparam int CTL_BIT_MS  = 1;
    localparam int CTL_BIT_IGN = 2;

    localparam int N_FLAGS   = 3;
    localparam int FLG_DONE  = 0;
    localparam int FLG_COLL  = 1;
    localparam int FLG_FAULT = 2;

    typedef struct packed {
        logic sel_ignore;
        logic master;
        logic enable;
    } ctl_t;
endpackage

// File: rtl/spi_sel_sync.sv
`timescale 1ns/1ps
module spi_sel_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], pin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_LVL}};
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_flag_arm.sv
`timescale 1ns/1ps
module spi_flag_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic stat_rd_i,
    input  logic clr_acc_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
        logic arm;
    } fa_t;

    fa_t  st_d, st_q;
    logic hit;

    always_comb begin
        st_d = st_q;
        hit  = clr_acc_i && st_q.arm;
        // set wins over a simultaneous clear
        if (set_i)    st_d.flag = 1'b1;
        else if (hit) st_d.flag = 1'b0;
        // status read arms only when it observes the flag set
        if (stat_rd_i)      st_d.arm = st_q.flag && !hit;
        else if (clr_acc_i) st_d.arm = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/spi_rx_hold.sv
`timescale 1ns/1ps
module spi_rx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] byte_i,
    output logic [DATA_W-1:0] byte_o
);
    logic [DATA_W-1:0] buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (capture_i) buf_d = byte_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign byte_o = buf_q;
endmodule

// File: rtl/spi_status_ctrl.sv
`timescale 1ns/1ps
module spi_status_ctrl
    import spi_stat_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_rd,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              data_rd,
    input  logic              data_wr,
    input  logic              ss_n_pin,
    input  logic              xfer_busy,
    input  logic              xfer_done,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              ctl_enable,
    output logic              ctl_master,
    output logic              ctl_sel_ignore,
    output logic              done_flag,
    output logic              collide_flag,
    output logic              fault_flag,
    output logic              irq_done,
    output logic              irq_fault,
    output logic              tx_load,
    output logic [DATA_W-1:0] rx_data
);
    ctl_t               ctl_d, ctl_q;
    logic               ss_sync;
    logic               fault_hit;
    logic               data_acc;
    logic [N_FLAGS-1:0] set_v, clr_v, flag_v;

    spi_sel_sync #(.STAGES(SYNC_STAGES), .RST_LVL(1'b1)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ss_n_pin),
        .sync_o (ss_sync)
    );

    always_comb begin
        data_acc  = data_rd || data_wr;
        fault_hit = ctl_q.enable && ctl_q.master && !ctl_q.sel_ignore && !ss_sync;

        set_v            = '0;
        set_v[FLG_DONE]  = xfer_done;
        set_v[FLG_COLL]  = data_wr && xfer_busy;
        set_v[FLG_FAULT] = fault_hit;

        clr_v            = '0;
        clr_v[FLG_DONE]  = data_acc;
        clr_v[FLG_COLL]  = data_acc;
        clr_v[FLG_FAULT] = ctl_wr;

        ctl_d = ctl_q;
        if (ctl_wr) begin
            ctl_d.master     = ctl_wdata[CTL_BIT_MS];
            ctl_d.sel_ignore = ctl_wdata[CTL_BIT_IGN];
            // enable stays locked while a fault is pending
            if (!flag_v[FLG_FAULT]) ctl_d.enable = ctl_wdata[CTL_BIT_EN];
        end
        if (fault_hit) begin
            ctl_d.enable = 1'b0;
            ctl_d.master = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        spi_flag_arm u_flag (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (set_v[g]),
            .stat_rd_i (stat_rd),
            .clr_acc_i (clr_v[g]),
            .flag_o    (flag_v[g])
        );
    end

    spi_rx_hold #(.DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (xfer_done && !flag_v[FLG_DONE]),
        .byte_i    (rx_byte),
        .byte_o    (rx_data)
    );

    assign ctl_enable     = ctl_q.enable;
    assign ctl_master     = ctl_q.master;
    assign ctl_sel_ignore = ctl_q.sel_ignore;
    assign done_flag      = flag_v[FLG_DONE];
    assign collide_flag   = flag_v[FLG_COLL];
    assign fault_flag     = flag_v[FLG_FAULT];
    assign irq_done       = flag_v[FLG_DONE];
    assign irq_fault      = flag_v[FLG_FAULT] && !ctl_q.sel_ignore;
    assign tx_load        = data_wr && !xfer_busy;
endmodule

// File: rtl/spi_status_ctrl_chk.sv
`timescale 1ns/1ps
module spi_status_ctrl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xfer_done,
    input logic              xfer_busy,
    input logic              data_wr,
    input logic              done_flag,
    input logic              fault_flag,
    input logic              ctl_enable,
    input logic              ctl_master,
    input logic              ctl_sel_ignore,
    input logic              tx_load,
    input logic [DATA_W-1:0] rx_data
);
    p_fault_drops_ctl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_flag) |-> (!ctl_enable && !ctl_master));

    p_ignore_blocks_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_sel_ignore |=> !$rose(fault_flag));

    p_enable_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fault_flag |=> !ctl_enable);

    p_collide_no_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && xfer_busy) |-> !tx_load);

    p_done_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(xfer_done));

    p_rx_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && xfer_done) |=> $stable(rx_data));
endmodule

bind spi_status_ctrl spi_status_ctrl_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_spi_status_ctrl.sv
`timescale 1ns/1ps
module tb_spi_status_ctrl;
    localparam int S_EN = 0, S_MS = 1, S_IGN = 2, S_DONE = 3, S_COLL = 4,
                   S_FLT = 5, S_IRQD = 6, S_IRQF = 7, S_RX = 8, S_LOAD = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stat_rd = 0, ctl_wr = 0, data_rd = 0, data_wr = 0;
    logic [2:0] ctl_wdata = '0;
    logic       ss_n_pin = 1'b1, xfer_busy = 0, xfer_done = 0;
    logic [7:0] rx_byte = '0;
    logic       ctl_enable, ctl_master, ctl_sel_ignore;
    logic       done_flag, collide_flag, fault_flag, irq_done, irq_fault, tx_load;
    logic [7:0] rx_data;

    spi_status_ctrl dut (.*);

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int         at;
        int         sel;
        logic [7:0] val;
        string      req;
    } exp_t;

    exp_t q[$];
    int   total = 0, bad = 0;
    bit   finished = 0;

    function automatic logic [7:0] observe(int sel);
        case (sel)
            S_EN:    return {7'd0, ctl_enable};
            S_MS:    return {7'd0, ctl_master};
            S_IGN:   return {7'd0, ctl_sel_ignore};
            S_DONE:  return {7'd0, done_flag};
            S_COLL:  return {7'd0, collide_flag};
            S_FLT:   return {7'd0, fault_flag};
            S_IRQD:  return {7'd0, irq_done};
            S_IRQF:  return {7'd0, irq_fault};
            S_RX:    return rx_data;
            default: return {7'd0, tx_load};
        endcase
    endfunction

    // driver side: queue an expectation for the state after the next edge
    task automatic expect_next(int sel, logic [7:0] v, string req);
        exp_t e;
        e.at = cyc + 1; e.sel = sel; e.val = v; e.req = req;
        q.push_back(e);
    endtask

    task automatic nxt();
        @(negedge clk);
        stat_rd = 0; ctl_wr = 0; data_rd = 0; data_wr = 0; xfer_done = 0; xfer_busy = 0;
    endtask

    // monitor: compares queued expectations after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0 && q[0].at <= cyc) begin
                exp_t e;
                e = q.pop_front();
                total++;
                if (observe(e.sel) !== e.val) begin
                    bad++;
                    $display("FAIL %s sel=%0d actual=%0h expected=%0h", e.req, e.sel,
                             observe(e.sel), e.val);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int s = S_EN; s <= S_RX; s++) expect_next(s, 8'h00, "R1");

        // R7 / R8: first byte captured, second discarded
        nxt(); xfer_done = 1; rx_byte = 8'hA5;
        expect_next(S_DONE, 1, "R7"); expect_next(S_IRQD, 1, "R7"); expect_next(S_RX, 8'hA5, "R8");
        nxt(); xfer_done = 1; rx_byte = 8'h3C;
        expect_next(S_RX, 8'hA5, "R8"); expect_next(S_DONE, 1, "R8");
        // R10 clear sequence
        nxt(); stat_rd = 1;
        expect_next(S_DONE, 1, "R10");
        nxt(); data_rd = 1;
        expect_next(S_DONE, 0, "R10"); expect_next(S_IRQD, 0, "R7");
        nxt(); xfer_done = 1; rx_byte = 8'h77;
        expect_next(S_RX, 8'h77, "R8"); expect_next(S_DONE, 1, "R7");

        // R10 via data write, R5 load when idle
        nxt(); stat_rd = 1;
        nxt(); data_wr = 1;
        expect_next(S_DONE, 0, "R10"); expect_next(S_LOAD, 1, "R5"); expect_next(S_COLL, 0, "R5");
        // R9: read with flag clear does not arm
        nxt(); stat_rd = 1;
        expect_next(S_DONE, 0, "R9");
        nxt(); xfer_done = 1; rx_byte = 8'h11;
        expect_next(S_DONE, 1, "R7"); expect_next(S_RX, 8'h11, "R8");
        nxt(); data_rd = 1;
        expect_next(S_DONE, 1, "R9");
        nxt(); stat_rd = 1;
        nxt(); data_rd = 1;
        expect_next(S_DONE, 0, "R10");

        // R5 collision
        nxt(); xfer_busy = 1; data_wr = 1;
        expect_next(S_COLL, 1, "R5"); expect_next(S_LOAD, 0, "R5");
        expect_next(S_IRQD, 0, "R5"); expect_next(S_IRQF, 0, "R5");
        nxt(); data_rd = 1;
        expect_next(S_COLL, 1, "R9");
        nxt(); stat_rd = 1;
        expect_next(S_COLL, 1, "R6");
        nxt(); data_rd = 1;
        expect_next(S_COLL, 0, "R6");

        // R2 mode fault timing
        nxt(); ctl_wr = 1; ctl_wdata = 3'b011;
        expect_next(S_EN, 1, "R4"); expect_next(S_MS, 1, "R4"); expect_next(S_IGN, 0, "R4");
        nxt(); ss_n_pin = 0;
        expect_next(S_FLT, 0, "R2");
        nxt();
        expect_next(S_FLT, 0, "R2"); expect_next(S_EN, 1, "R2");
        nxt();
        expect_next(S_FLT, 1, "R2"); expect_next(S_EN, 0, "R2");
        expect_next(S_MS, 0, "R2"); expect_next(S_IRQF, 1, "R3");
        // R4 lock and clear
        nxt(); ss_n_pin = 1; ctl_wr = 1; ctl_wdata = 3'b011;
        expect_next(S_FLT, 1, "R4"); expect_next(S_EN, 0, "R4"); expect_next(S_MS, 1, "R4");
        nxt(); stat_rd = 1;
        expect_next(S_FLT, 1, "R4");
        nxt(); ctl_wr = 1; ctl_wdata = 3'b001;
        expect_next(S_FLT, 0, "R4"); expect_next(S_EN, 0, "R4"); expect_next(S_IRQF, 0, "R3");
        nxt(); ctl_wr = 1; ctl_wdata = 3'b011;
        expect_next(S_EN, 1, "R4"); expect_next(S_MS, 1, "R4");

        // R3 ignore blocks fault
        nxt(); ctl_wr = 1; ctl_wdata = 3'b111;
        expect_next(S_IGN, 1, "R3");
        nxt(); ss_n_pin = 0;
        nxt();
        nxt();
        nxt();
        expect_next(S_FLT, 0, "R3"); expect_next(S_EN, 1, "R3"); expect_next(S_MS, 1, "R3");
        nxt(); ss_n_pin = 1;
        nxt();
        nxt();

        // R3 interrupt gate
        nxt(); ctl_wr = 1; ctl_wdata = 3'b011;
        expect_next(S_IGN, 0, "R3");
        nxt(); ss_n_pin = 0;
        nxt();
        nxt();
        expect_next(S_FLT, 1, "R2"); expect_next(S_IRQF, 1, "R3");
        nxt(); ss_n_pin = 1; ctl_wr = 1; ctl_wdata = 3'b100;
        expect_next(S_FLT, 1, "R3"); expect_next(S_IGN, 1, "R3"); expect_next(S_IRQF, 0, "R3");

        nxt();
        repeat (3) @(posedge clk);
        #3;
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule